// File: doc/BRIEF.md
# Looping conversion instruction sequencer

This block paces a data-acquisition front end through a short program of up to eight stored conversion instructions. A pointer addresses an external instruction memory. For each word the controller walks a fixed chain of phases: fetch, start/calibration check, an optional calibration window, an optional programmable delay, input acquisition, a limit read, the conversion or comparison window, and an optional second comparison. It exposes the active phase as a code and as a one-hot strobe vector, so the converter, calibration engine and comparator can key off these timing windows. Those blocks are not part of this design.

Each phase holds for a cycle budget. The budget is either fixed or computed from the configuration bits, the delay register and fields of the current instruction. At the end of an instruction the pointer either steps forward or, when the instruction asks for it, jumps back to entry zero. A program shorter than eight words must therefore mark its last word. A pause input parks the machine in the check phase at any time without losing the pointer. A low start input keeps it parked there.

Top module: `acq_seq_ctrl`

## Requirements
- R1: After reset the phase code is 1 (check/idle), the one-hot strobe has only bit 1 set and the pointer is 0.
- R2: In phase 1 the machine stays put while `start` is low. With `start` high and `pause` low it leaves phase 1 after exactly one cycle.
- R3: At the end of an instruction whose loop bit is clear, the pointer increments by one and wraps from 7 to 0, so a program with no loop bit runs all eight entries in turn.
- R4: At the end of an instruction whose loop bit (instruction bit 1) is set, the pointer returns to 0.
- R5: `status_word` carries the pointer in bits 10:8 and the phase code in bits 2:0. All other bits are 0.
- R6: The calibration phase (code 2) lasts 76 cycles when config bit 2 or bit 6 is set, and 4944 cycles when config bit 3 is set. Bit 3 wins if both kinds are set. It is skipped when none of these bits is set.
- R7: The delay phase (code 3) occurs only when instruction bit 2 is set. It lasts T+1 cycles, where T is `tmr_val`.
- R8: The acquisition phase (code 7) lasts 2+2D cycles for an 8-bit instruction (bit 3 set, bit 4 clear). Otherwise it lasts 9+2D cycles. D is instruction bits 15:12.
- R9: The conversion phase (code 5) lasts 5 cycles in compare mode (instruction bit 4 set), 21 cycles at 8-bit resolution, and 44 cycles otherwise. Compare mode adds a second compare phase (code 6) of 5 cycles.
- R10: Fetch (code 0) and limit read (code 4) last one cycle each. The phase order is 0, 1, 2 (if calibrating), 3 (if delaying), 7, 4, 5, 6 (if compare mode), then 0 again. The pointer changes on entry to phase 0.
- R11: A high `pause` forces phase 1 on the next cycle from any phase, leaving the pointer unchanged. After release, the same instruction restarts from phase 1.
- R12: `phase_oh` always has exactly one bit set, and that bit's index is the phase code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run enable, sampled in the check phase |
| pause | input | 1 | Forces the check phase while high |
| cfg | input | CFG_W (8) | Configuration bits; bits 2, 3 and 6 select calibration |
| tmr_val | input | TMR_W (16) | Delay phase count T |
| instr_addr | output | PTR_W (3) | Instruction memory address (the pointer) |
| instr_data | input | 16 | Instruction memory read data for `instr_addr` |
| phase_code | output | 3 | Active phase number |
| phase_oh | output | 8 | One-hot phase strobes |
| status_word | output | 16 | Pointer in 10:8, phase in 2:0 |

## Verification
The bench builds the block with its default parameters: a 3-bit pointer, a 16-bit delay count and calibration budgets of 76 and 4944 cycles. With these values a full eight-entry wrap and the long calibration window are both reachable within a few thousand cycles. Each vector measures every phase's length across one complete instruction and the pointer that follows it. The directed tests cover parking, pause recovery and the exact phase order.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

   localparam int INSTR_W   = 16;
   localparam int LOOP_BIT  = 1;
   localparam int TMR_BIT   = 2;
   localparam int RES8_BIT  = 3;
   localparam int WDOG_BIT  = 4;
   localparam int DW_LSB    = 12;
   localparam int CFG_CAL_A = 2;
   localparam int CFG_CAL_B = 6;
   localparam int CFG_CAL_L = 3;

   typedef enum logic [2:0] {
      PH_FETCH = 3'd0,
      PH_CHECK = 3'd1,
      PH_CAL   = 3'd2,
      PH_TIMER = 3'd3,
      PH_LIMIT = 3'd4,
      PH_CONV  = 3'd5,
      PH_WDX   = 3'd6,
      PH_ACQ   = 3'd7
   } phase_t;

   typedef struct packed {
      logic [3:0] dwell;
      logic       wdog;
      logic       res8;
      logic       tmr_en;
      logic       loop;
   } instr_f_t;

   function automatic instr_f_t decode_instr(input logic [INSTR_W-1:0] w);
      instr_f_t f;
      f.dwell  = w[DW_LSB +: 4];
      f.wdog   = w[WDOG_BIT];
      f.res8   = w[RES8_BIT];
      f.tmr_en = w[TMR_BIT];
      f.loop   = w[LOOP_BIT];
      return f;
   endfunction

endpackage

// File: rtl/acq_seq_len.sv
module acq_seq_len
   import acq_seq_pkg::*;
#(
   parameter int CFG_W          = 8,
   parameter int TMR_W          = 16,
   parameter int CAL_SHORT      = 76,
   parameter int CAL_LONG       = 4944,
   parameter int CONV_HI        = 44,
   parameter int CONV_LO        = 21,
   parameter int WD_CYC         = 5,
   parameter int ACQ_HI_BASE    = 9,
   parameter int ACQ_LO_BASE    = 2,
   parameter bit CAL_LONG_FIRST = 1'b1
) (
   input  phase_t             nxt,
   input  instr_f_t           fld,
   input  logic [CFG_W-1:0]   cfg,
   input  logic [TMR_W-1:0]   tmr_val,
   output logic               cal_req,
   output logic [TMR_W-1:0]   len_m1
);
   localparam logic [TMR_W-1:0] CAL_S_M1 = TMR_W'(CAL_SHORT - 1);
   localparam logic [TMR_W-1:0] CAL_L_M1 = TMR_W'(CAL_LONG - 1);
   localparam logic [TMR_W-1:0] CONV_H_M1 = TMR_W'(CONV_HI - 1);
   localparam logic [TMR_W-1:0] CONV_L_M1 = TMR_W'(CONV_LO - 1);
   localparam logic [TMR_W-1:0] WD_M1    = TMR_W'(WD_CYC - 1);
   localparam logic [TMR_W-1:0] ACQ_H_M1 = TMR_W'(ACQ_HI_BASE - 1);
   localparam logic [TMR_W-1:0] ACQ_L_M1 = TMR_W'(ACQ_LO_BASE - 1);

   logic             short_req, long_req, unused_cfg;
   logic [TMR_W-1:0] cal_m1, acq_m1, conv_m1, dwell2;

   assign short_req  = cfg[CFG_CAL_A] | cfg[CFG_CAL_B];
   assign long_req   = cfg[CFG_CAL_L];
   assign cal_req    = short_req | long_req;
   assign unused_cfg = ^cfg;

   generate
      if (CAL_LONG_FIRST) begin : g_long_first
         assign cal_m1 = long_req ? CAL_L_M1 : CAL_S_M1;
      end else begin : g_short_first
         assign cal_m1 = short_req ? CAL_S_M1 : CAL_L_M1;
      end
   endgenerate

   assign dwell2  = TMR_W'({fld.dwell, 1'b0});
   assign acq_m1  = ((fld.res8 && !fld.wdog) ? ACQ_L_M1 : ACQ_H_M1) + dwell2;
   assign conv_m1 = fld.wdog ? WD_M1 : (fld.res8 ? CONV_L_M1 : CONV_H_M1);

   always_comb begin
      unique case (nxt)
         PH_CAL:   len_m1 = cal_m1;
         PH_TIMER: len_m1 = tmr_val;
         PH_ACQ:   len_m1 = acq_m1;
         PH_CONV:  len_m1 = conv_m1;
         PH_WDX:   len_m1 = WD_M1;
         default:  len_m1 = '0;
      endcase
   end

   always_comb begin
      if (nxt == PH_WDX) a_r9_wdx_len : assert (len_m1 == WD_M1);
   end
endmodule

// File: rtl/acq_seq_ptr.sv
module acq_seq_ptr #(
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             loop,
   output logic [PTR_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= loop ? '0 : ptr + PTR_W'(1);
   end

   // R4: a marked instruction sends the pointer home
   a_r4_loop_home : assert property (@(posedge clk) disable iff (!rst_n)
      (adv && loop) |=> (ptr == '0));
   // R3: otherwise it steps by one, wrapping naturally
   a_r3_step : assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !loop) |=> (ptr == $past(ptr) + PTR_W'(1)));
   // R11: no end of instruction, no pointer change
   a_r11_ptr_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr));
endmodule

// File: rtl/acq_seq_phase.sv
module acq_seq_phase
   import acq_seq_pkg::*;
#(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             pause,
   input  logic             cal_req,
   input  logic             tmr_en,
   input  logic             wdog,
   input  logic [TMR_W-1:0] len_m1,
   output phase_t           phase,
   output phase_t           nxt,
   output logic             adv
);
   logic [TMR_W-1:0] cnt;
   logic             done;

   assign done = (cnt == '0);

   always_comb begin
      nxt = phase;
      adv = 1'b0;
      if (pause) begin
         nxt = PH_CHECK;
      end else if (done) begin
         unique case (phase)
            PH_FETCH: nxt = PH_CHECK;
            PH_CHECK: if (start) nxt = cal_req ? PH_CAL : (tmr_en ? PH_TIMER : PH_ACQ);
            PH_CAL:   nxt = tmr_en ? PH_TIMER : PH_ACQ;
            PH_TIMER: nxt = PH_ACQ;
            PH_ACQ:   nxt = PH_LIMIT;
            PH_LIMIT: nxt = PH_CONV;
            PH_CONV: begin
               if (wdog) nxt = PH_WDX;
               else begin
                  nxt = PH_FETCH;
                  adv = 1'b1;
               end
            end
            PH_WDX: begin
               nxt = PH_FETCH;
               adv = 1'b1;
            end
            default: nxt = PH_CHECK;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_CHECK;
         cnt   <= '0;
      end else begin
         phase <= nxt;
         if (pause || done) cnt <= len_m1;
         else               cnt <= cnt - TMR_W'(1);
      end
   end

   // R11: pause parks the machine in the check phase
   a_r11_pause : assert property (@(posedge clk) disable iff (!rst_n)
      pause |=> (phase == PH_CHECK));
   // R2: low start keeps the machine parked
   a_r2_park : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CHECK && !start) |=> (phase == PH_CHECK));
   // R10: fetch is a single cycle followed by the check phase
   a_r10_fetch : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FETCH) |=> (phase == PH_CHECK));
   // R10: limit read is a single cycle followed by conversion
   a_r10_limit : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LIMIT && !pause) |=> (phase == PH_CONV));
   // R10: a phase with budget left does not move
   a_r10_dwell : assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !pause) |=> $stable(phase));
endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
   import acq_seq_pkg::*;
#(
   parameter int PTR_W          = 3,
   parameter int CFG_W          = 8,
   parameter int TMR_W          = 16,
   parameter int CAL_SHORT      = 76,
   parameter int CAL_LONG       = 4944,
   parameter int CONV_HI        = 44,
   parameter int CONV_LO        = 21,
   parameter int WD_CYC         = 5,
   parameter bit CAL_LONG_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               pause,
   input  logic [CFG_W-1:0]   cfg,
   input  logic [TMR_W-1:0]   tmr_val,
   output logic [PTR_W-1:0]   instr_addr,
   input  logic [INSTR_W-1:0] instr_data,
   output logic [2:0]         phase_code,
   output logic [7:0]         phase_oh,
   output logic [15:0]        status_word
);
   localparam int NUM_PH = 8;

   generate
      if (PTR_W < 1 || PTR_W > 3) begin : g_bad_ptr
         $error("PTR_W must lie in 1..3 to fit status bits 10:8");
      end
      if (CFG_W < 7) begin : g_bad_cfg
         $error("CFG_W must cover configuration bit 6");
      end
      if (CAL_LONG > (2 ** TMR_W) || CAL_SHORT < 1 || WD_CYC < 1) begin : g_bad_len
         $error("phase budgets must be nonzero and fit TMR_W");
      end
   endgenerate

   phase_t           phase, nxt;
   logic             adv, cal_req, unused_instr;
   logic [TMR_W-1:0] len_m1;
   logic [PTR_W-1:0] ptr;
   instr_f_t         fld_q, fld_cur;

   assign unused_instr = ^instr_data;
   assign fld_cur = (phase == PH_FETCH || phase == PH_CHECK) ? decode_instr(instr_data) : fld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fld_q <= '0;
      else if (phase == PH_FETCH || phase == PH_CHECK) fld_q <= fld_cur;
   end

   acq_seq_len #(
      .CFG_W(CFG_W), .TMR_W(TMR_W), .CAL_SHORT(CAL_SHORT), .CAL_LONG(CAL_LONG),
      .CONV_HI(CONV_HI), .CONV_LO(CONV_LO), .WD_CYC(WD_CYC),
      .ACQ_HI_BASE(9), .ACQ_LO_BASE(2), .CAL_LONG_FIRST(CAL_LONG_FIRST)
   ) u_len (
      .nxt(nxt), .fld(fld_cur), .cfg(cfg), .tmr_val(tmr_val),
      .cal_req(cal_req), .len_m1(len_m1)
   );

   acq_seq_phase #(.TMR_W(TMR_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .start(start), .pause(pause),
      .cal_req(cal_req), .tmr_en(fld_cur.tmr_en), .wdog(fld_cur.wdog),
      .len_m1(len_m1), .phase(phase), .nxt(nxt), .adv(adv)
   );

   acq_seq_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .adv(adv), .loop(fld_q.loop), .ptr(ptr)
   );

   assign instr_addr = ptr;
   assign phase_code = phase;

   for (genvar i = 0; i < NUM_PH; i++) begin : g_strobe
      assign phase_oh[i] = (phase_code == 3'(i));
   end

   always_comb begin
      status_word = '0;
      status_word[8 +: PTR_W] = ptr;
      status_word[2:0] = phase_code;
   end

   // R12: exactly one strobe is active
   a_r12_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phase_oh) == 1);
   // R5: status fields follow the pointer and the phase
   a_r5_status : assert property (@(posedge clk) disable iff (!rst_n)
      (status_word[10:8] == 3'(instr_addr)) && (status_word[2:0] == phase_code));
endmodule

// File: tb/tb_acq_seq_ctrl.sv
module tb_acq_seq_ctrl;
   localparam int CLK_PERIOD = 10;

   // {instr[15:0], cfg[7:0], tmr[15:0], total[15:0], next_ptr[7:0]}
   localparam logic [63:0] VEC [8] = '{
      {16'h0000, 8'h00, 16'd0,  16'd56,   8'd2},
      {16'h5008, 8'h00, 16'd0,  16'd36,   8'd2},
      {16'hF010, 8'h00, 16'd0,  16'd52,   8'd2},
      {16'h2004, 8'h00, 16'd10, 16'd71,   8'd2},
      {16'h0002, 8'h04, 16'd0,  16'd132,  8'd0},
      {16'h000A, 8'h40, 16'd0,  16'd102,  8'd0},
      {16'h0006, 8'h08, 16'd0,  16'd5001, 8'd0},
      {16'h0000, 8'h48, 16'd0,  16'd5000, 8'd2}
   };

   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, pause = 1'b0;
   logic [7:0]  cfg = '0;
   logic [15:0] tmr_val = '0;
   logic [2:0]  instr_addr, phase_code;
   logic [15:0] instr_data, status_word;
   logic [7:0]  phase_oh;
   logic [15:0] mem [8];

   int n_tests = 0, n_fail = 0;
   int dur [8];
   int tot;
   logic [15:0] v_instr, v_tmr, v_tot;
   logic [7:0]  v_cfg, v_ptr;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign instr_data = mem[instr_addr];

   acq_seq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start(start), .pause(pause), .cfg(cfg),
      .tmr_val(tmr_val), .instr_addr(instr_addr), .instr_data(instr_data),
      .phase_code(phase_code), .phase_oh(phase_oh), .status_word(status_word)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic fill(input logic [15:0] w);
      for (int i = 0; i < 8; i++) mem[i] = w;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_fetch();
      while (phase_code != 3'd0) @(negedge clk);
   endtask

   task automatic measure();
      for (int i = 0; i < 8; i++) dur[i] = 0;
      tot = 0;
      do begin
         dur[phase_code]++;
         tot++;
         @(negedge clk);
      end while (phase_code != 3'd0);
   endtask

   function automatic int exp_dur(input int ph, input logic [15:0] w,
                                  input logic [7:0] c, input logic [15:0] t);
      int d = int'(w[15:12]);
      case (ph)
         2: return c[3] ? 4944 : ((c[2] | c[6]) ? 76 : 0);
         3: return w[2] ? int'(t) + 1 : 0;
         7: return (w[3] && !w[4]) ? 2 + 2*d : 9 + 2*d;
         5: return w[4] ? 5 : (w[3] ? 21 : 44);
         6: return w[4] ? 5 : 0;
         default: return 1;
      endcase
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      fill(16'h0000);
      // Directed: reset state and parking
      do_reset();
      chk("R1 phase after reset", int'(phase_code), 1);
      chk("R1 strobe after reset", int'(phase_oh), 2);
      chk("R5 status after reset", int'(status_word), 16'h0001);
      repeat (20) @(negedge clk);
      chk("R2 parked with start low", int'(phase_code), 1);
      start = 1'b1;
      @(negedge clk);
      chk("R2 check lasts one cycle", int'(phase_code), 7);
      chk("R12 strobe tracks phase", int'(phase_oh), 128);

      // Vector table: per-phase budgets and next pointer
      for (int v = 0; v < 8; v++) begin
         {v_instr, v_cfg, v_tmr, v_tot, v_ptr} = VEC[v];
         start = 1'b0;
         fill(v_instr);
         cfg = v_cfg;
         tmr_val = v_tmr;
         do_reset();
         start = 1'b1;
         wait_fetch();
         measure();
         chk("R6 calibration cycles", dur[2], exp_dur(2, v_instr, v_cfg, v_tmr));
         chk("R7 delay cycles", dur[3], exp_dur(3, v_instr, v_cfg, v_tmr));
         chk("R8 acquisition cycles", dur[7], exp_dur(7, v_instr, v_cfg, v_tmr));
         chk("R9 conversion cycles", dur[5], exp_dur(5, v_instr, v_cfg, v_tmr));
         chk("R9 second compare cycles", dur[6], exp_dur(6, v_instr, v_cfg, v_tmr));
         chk("R10 fetch and limit single cycle", dur[0] + dur[4], 2);
         chk("R10 instruction total", tot, int'(v_tot));
         if (v_ptr == 8'd0) chk("R4 pointer after loop", int'(status_word[10:8]), 0);
         else               chk("R3 pointer after step", int'(status_word[10:8]), int'(v_ptr));
      end

      // Directed: full wrap without loop bits
      start = 1'b0; fill(16'h0000); cfg = '0; tmr_val = '0;
      do_reset();
      start = 1'b1;
      for (int k = 1; k <= 9; k++) begin
         wait_fetch();
         chk("R3 wrap sequence", int'(status_word[10:8]), k % 8);
         chk("R5 address matches status", int'(instr_addr), k % 8);
         @(negedge clk);
      end

      // Directed: loop bit on entry 2
      start = 1'b0; fill(16'h0000); mem[2] = 16'h0002;
      do_reset();
      start = 1'b1;
      for (int k = 1; k <= 6; k++) begin
         wait_fetch();
         chk("R4 short program sequence", int'(status_word[10:8]), k % 3);
         @(negedge clk);
      end

      // Directed: pause during acquisition
      start = 1'b0; fill(16'h0000);
      do_reset();
      start = 1'b1;
      while (phase_code != 3'd7) @(negedge clk);
      repeat (3) @(negedge clk);
      pause = 1'b1;
      @(negedge clk);
      chk("R11 pause forces check", int'(phase_code), 1);
      repeat (5) @(negedge clk);
      chk("R11 stays in check while paused", int'(phase_code), 1);
      chk("R11 pointer kept under pause", int'(status_word[10:8]), 0);
      pause = 1'b0;
      @(negedge clk);
      chk("R11 resumes acquisition", int'(phase_code), 7);
      begin
         int acq_n = 0;
         while (phase_code == 3'd7) begin
            acq_n++;
            @(negedge clk);
         end
         chk("R11 restarted acquisition full length", acq_n, 9);
      end
      chk("R11 pointer unchanged after resume", int'(status_word[10:8]), 0);
      wait_fetch();
      chk("R3 pointer steps after resumed instruction", int'(status_word[10:8]), 1);

      // Directed: phase order with every optional phase
      start = 1'b0; fill(16'h0014); cfg = 8'h04; tmr_val = 16'd3;
      do_reset();
      start = 1'b1;
      wait_fetch();
      begin
         int seqv [8];
         int n = 0;
         logic [2:0] last;
         seqv[0] = int'(phase_code);
         n = 1;
         last = phase_code;
         @(negedge clk);
         while (phase_code != 3'd0) begin
            if (phase_code != last && n < 8) begin
               seqv[n] = int'(phase_code);
               n++;
            end
            last = phase_code;
            @(negedge clk);
         end
         chk("R10 number of phases", n, 8);
         chk("R10 order step 1", seqv[1], 1);
         chk("R10 order step 2", seqv[2], 2);
         chk("R10 order step 3", seqv[3], 3);
         chk("R10 order step 4", seqv[4], 7);
         chk("R10 order step 5", seqv[5], 4);
         chk("R10 order step 6", seqv[6], 5);
         chk("R10 order step 7", seqv[7], 6);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule